// File: doc/BRIEF.md
# Thread Context Run-State Controller

This block keeps the run state of a small array of hardware thread contexts. Each context is either active or stopped. A caller names one context per cycle and raises a halt strobe or a restore strobe for it. A halt stops an active context and saves that context's next fetch address in its own resume register. A restore restarts a stopped context. It rebuilds a three-deep fetch sequence from the saved resume address and marks the context active.

Every change commits on a single clock edge. A one-cycle completion pulse follows any request that took effect. Requests that do not apply are dropped without any effect: a halt of a stopped context, a restore of a running context, or a restore that arrives together with a halt. After reset only context 0 runs, and every resume address is zero.

Top module: `thread_run_ctl`

## Requirements
- R1: After reset, `active_o` has only bit 0 set, every resume address is 0, `pc_o`/`pc_nx_o`/`pc_nnx_o` read 0/4/8 and `done_o` is 0.
- R2: A halt strobe for an active context clears its `active_o` bit on the next edge. The same edge copies that context's slice of `next_pc_all` into its slice of `resume_all` and raises `done_o`.
- R3: A halt strobe for a context that is not active changes no output, and `done_o` stays 0.
- R4: When only the restore strobe is raised for an inactive context, the next edge does four things. It loads `pc_o` with that context's resume address, loads `pc_nx_o` with that address plus 4 and `pc_nnx_o` with it plus 8, sets the context's `active_o` bit, and raises `done_o`.
- R5: A restore strobe for an active context changes no output, and `done_o` stays 0.
- R6: When halt and restore are raised in the same cycle, the restore is dropped. Only the halt rule (R2/R3) applies, so the PC outputs stay unchanged.
- R7: `done_o` is high for exactly the one cycle after a request that took effect. The contexts that were not selected keep their active bits and resume addresses.
- R8: The +4 and +8 offsets wrap modulo 2^AW; for example, resume address 0xFFFFFFFC restores to FFFFFFFC/00000000/00000004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_sel | input | IW | Index of the context the request targets (below NCTX) |
| halt_stb | input | 1 | Halt request for the selected context |
| restore_stb | input | 1 | Restore request for the selected context |
| next_pc_all | input | NCTX*AW | Next fetch address of every context, context c in bits c*AW +: AW |
| active_o | output | NCTX | Per-context active flag |
| resume_all | output | NCTX*AW | Saved resume address of every context, same packing as next_pc_all |
| pc_o | output | AW | Reloaded fetch address |
| pc_nx_o | output | AW | Reloaded fetch address plus 4 |
| pc_nnx_o | output | AW | Reloaded fetch address plus 8 |
| done_o | output | 1 | One-cycle pulse after an effective halt or restore |

## Verification
The embedded properties check the following on every cycle:
- a halt saves the selected next address and stops the context;
- a restore yields a sequence spaced 4 and 8 apart;
- dropped requests leave the flags and PC outputs still, with no pulse;
- at most one active bit moves per edge.

The bench covers what needs a longer history. It follows every context through a fixed sequence of stimulus in which resume addresses from earlier halts are restored rounds later. It checks that the other contexts' resume registers survive, that the reset values hold, and that the wrap near the top of the address space gives the right result.

// File: rtl/thread_run_ctl.sv
module thread_run_ctl #(
  parameter int NCTX = 4,
  parameter int AW   = 32,
  localparam int IW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IW-1:0]      ctx_sel,
  input  logic               halt_stb,
  input  logic               restore_stb,
  input  logic [NCTX*AW-1:0] next_pc_all,
  output logic [NCTX-1:0]    active_o,
  output logic [NCTX*AW-1:0] resume_all,
  output logic [AW-1:0]      pc_o,
  output logic [AW-1:0]      pc_nx_o,
  output logic [AW-1:0]      pc_nnx_o,
  output logic               done_o
);

  logic [AW-1:0] resume_q [NCTX];
  logic [NCTX-1:0] act_q;
  logic [AW-1:0] sel_npc, sel_resume;
  logic sel_act, do_halt, do_rest;

  assign sel_npc    = next_pc_all[ctx_sel*AW +: AW];
  assign sel_resume = resume_q[ctx_sel];
  assign sel_act    = act_q[ctx_sel];
  assign do_halt    = halt_stb && sel_act;
  assign do_rest    = restore_stb && !halt_stb && !sel_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= NCTX'(1);
      pc_o     <= '0;
      pc_nx_o  <= AW'(4);
      pc_nnx_o <= AW'(8);
      done_o   <= 1'b0;
      for (int c = 0; c < NCTX; c++) resume_q[c] <= '0;
    end else begin
      done_o <= do_halt || do_rest;
      if (do_halt) begin
        act_q[ctx_sel]    <= 1'b0;
        resume_q[ctx_sel] <= sel_npc;
      end
      if (do_rest) begin
        act_q[ctx_sel] <= 1'b1;
        pc_o     <= sel_resume;
        pc_nx_o  <= sel_resume + AW'(4);
        pc_nnx_o <= sel_resume + AW'(8);
      end
    end
  end

  assign active_o = act_q;

  for (genvar g = 0; g < NCTX; g++) begin : g_out
    assign resume_all[g*AW +: AW] = resume_q[g];
  end

  AST_HALT_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_stb && active_o[ctx_sel]) |=>
      (!active_o[$past(ctx_sel)] && resume_q[$past(ctx_sel)] == $past(sel_npc) && done_o)); // R2
  AST_HALT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_stb && !active_o[ctx_sel]) |=> ($stable(active_o) && $stable(pc_o) && !done_o)); // R3
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_stb && !halt_stb && !active_o[ctx_sel]) |=>
      (active_o[$past(ctx_sel)] && pc_o == $past(sel_resume) &&
       pc_nx_o == pc_o + AW'(4) && pc_nnx_o == pc_o + AW'(8) && done_o)); // R4
  AST_RESTORE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_stb && !halt_stb && active_o[ctx_sel]) |=> ($stable(active_o) && $stable(pc_o) && !done_o)); // R5
  AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_stb && restore_stb) |=> ($stable(pc_o) && $stable(pc_nx_o) && $stable(pc_nnx_o))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_stb && !restore_stb) |=> ($stable(active_o) && $stable(resume_all) && !done_o)); // R7
  AST_ONE_FLAG_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(active_o ^ $past(active_o)) <= 1)); // R7

endmodule

// File: tb/sim_thread_run_ctl.sv
module sim_thread_run_ctl;
  localparam int N = 4;
  localparam int AW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] ctx_sel = '0;
  logic halt_stb = 0, restore_stb = 0;
  logic [N*AW-1:0] next_pc_all = '0;
  logic [N-1:0] active_o;
  logic [N*AW-1:0] resume_all;
  logic [AW-1:0] pc_o, pc_nx_o, pc_nnx_o;
  logic done_o;

  int checks = 0, errors = 0;
  logic [N-1:0] m_act;
  logic [AW-1:0] m_res [N];
  logic [AW-1:0] m_pc;
  logic m_done;

  always #10 clk = ~clk;

  thread_run_ctl #(.NCTX(N), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .halt_stb(halt_stb),
    .restore_stb(restore_stb), .next_pc_all(next_pc_all), .active_o(active_o),
    .resume_all(resume_all), .pc_o(pc_o), .pc_nx_o(pc_nx_o), .pc_nnx_o(pc_nnx_o),
    .done_o(done_o));

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "active", AW'(active_o), AW'(m_act));
    chk(tag, "done", AW'(done_o), AW'(m_done));
    chk(tag, "pc", pc_o, m_pc);
    chk(tag, "pc+4", pc_nx_o, m_pc + 32'd4);
    chk(tag, "pc+8", pc_nnx_o, m_pc + 32'd8);
    for (int c = 0; c < N; c++) chk(tag, "resume", resume_all[c*AW +: AW], m_res[c]);
  endtask

  task automatic do_op(int idx, bit h, bit r, logic [AW-1:0] npc);
    string tag;
    for (int c = 0; c < N; c++) next_pc_all[c*AW +: AW] = 32'hA000_0000 + c * 32'h100 + npc;
    next_pc_all[idx*AW +: AW] = npc;
    ctx_sel = idx[1:0];
    halt_stb = h;
    restore_stb = r;
    m_done = 0;
    if (h && r) tag = "R6";
    else if (h) tag = m_act[idx] ? "R2" : "R3";
    else if (r) tag = m_act[idx] ? "R5" : (m_res[idx] > 32'hFFFF_FFF7 ? "R8" : "R4");
    else tag = "R7";
    if (h) begin
      if (m_act[idx]) begin m_act[idx] = 0; m_res[idx] = npc; m_done = 1; end
    end else if (r && !m_act[idx]) begin
      m_act[idx] = 1; m_pc = m_res[idx]; m_done = 1;
    end
    @(negedge clk);
    halt_stb = 0;
    restore_stb = 0;
    check_all(tag);
    @(negedge clk);
    m_done = 0;
    check_all("R7");
  endtask

  initial begin
    fork
      begin
        m_act = 4'b0001; m_pc = 0; m_done = 0;
        for (int c = 0; c < N; c++) m_res[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");
        for (int rnd = 0; rnd < 3; rnd++)
          for (int idx = 0; idx < N; idx++)
            for (int op = 0; op < 6; op++) begin
              logic [AW-1:0] npc;
              npc = (rnd == 2) ? 32'hFFFF_FFF0 + idx * 4 + op * 0
                               : 32'h0040_0000 + rnd * 32'h1000 + idx * 32'h40 + op * 4;
              case (op)
                0: do_op(idx, 0, 0, npc);
                1: do_op(idx, 1, 0, npc);
                2: do_op(idx, 0, 1, npc);
                3: do_op(idx, 0, 1, npc);
                4: do_op(idx, 1, 1, npc);
                default: do_op(idx, 1, 1, npc);
              endcase
            end
        // restore after a halt that saved the wrap address (R8)
        do_op(3, 0, 1, 32'h0);
        do_op(3, 1, 0, 32'h1234_5678);
        do_op(3, 0, 1, 32'h0);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule